// File: doc/BRIEF.md
# Programmable Tone Beep Generator

This block produces a square-wave beep for a small audio transducer. A divide-by-two phase toggle feeds a free-running counter, so the counter advances once every two system clocks. Software picks one counter bit as the tone source by setting a single bit in a tap-select register. It turns the tone on and off with a one-bit enable register. The output is registered. It is driven low whenever the beep is disabled or the tap selection is not a single valid bit.

The power-saving clock logic reports the current system clock ratio on a two-bit input. When the clock runs at half speed, the effective tap is moved one counter bit lower. At one thirty-second speed it is moved five bits lower. The tone pitch therefore stays about the same as at full speed. The corrected index is clamped at counter bit 0. Both registers are reached through a simple single-cycle write strobe, and a combinational read path is selected by a one-bit address. The block has no data stream, so every pin is a plain control or status signal.

Top module: `tone_beep_gen`

## Requirements
- R1: After reset `beep_out` is 0, both registers read 0 and the counter and its phase toggle are 0.
- R2: The enable register sits at `reg_addr`=0. Only bit 0 is stored, and bit 0 = 1 enables the beep. Writes to bits 31:1 are ignored, and those bits read 0.
- R3: The tap-select register sits at `reg_addr`=1. Only bits 18:10 are stored, and bit k selects counter bit k. All other bits are ignored on write and read 0.
- R4: The counter starts at 0 and increments by one on every second clock edge after reset. It keeps running whether or not the beep is enabled.
- R5: At `clk_ratio`=0 (full speed), `beep_out` on each edge takes the value the selected counter bit had just before that edge. Selecting bit 10 gives a period of 4096 clocks (system clock / 2^12).
- R6: `clk_ratio`=1 (half speed) uses the counter bit one below the selected one. `clk_ratio`=2 (1/32 speed) uses the bit five below. `clk_ratio`=3 is treated as full speed. Bit 11 at ratio 1, and bit 15 at ratio 2, each give a 4096-clock period.
- R7: If the tap-select register holds no set bit, or more than one, `beep_out` is 0 from the next edge onward.
- R8: While the enable bit is 0, `beep_out` is 0 from the next edge onward. After re-enabling, the tone resumes in the phase of the still-running counter.
- R9: A register write takes effect on the edge that carries `reg_wr`. `beep_out` reflects the new value one edge later, and `reg_rdata` reflects it at once after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 1 | Register select: 0 enable, 1 tap select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| clk_ratio | input | 2 | Current system clock ratio: 0 full, 1 half, 2 one thirty-second, 3 as full |
| beep_out | output | 1 | Square-wave tone output |

## Verification
`reg_rdata` is due in the same cycle as the address, and it shows a write from the following cycle. `beep_out` is due one edge after the enable, tap and ratio values that produce it. It therefore reflects a register write two edges after `reg_wr` is seen.

The bench keeps its own counter, phase and register state. On each rising edge it computes the next expected output from the values held before that edge. It compares `beep_out` and `reg_rdata` at the following falling edge, and it drives inputs just after rising edges so that every sample lands on settled values. Separate period measurements between rising edges of `beep_out` confirm the 4096-clock pitch at each ratio.

// File: rtl/beep_pkg.sv
package beep_pkg;
  typedef enum logic [1:0] {
    RATIO_FULL = 2'd0,
    RATIO_HALF = 2'd1,
    RATIO_SLOW = 2'd2,
    RATIO_RSVD = 2'd3
  } clk_ratio_e;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned HALF_SHIFT = 1;
  localparam int unsigned SLOW_SHIFT = 5;
endpackage

// File: rtl/beep_half_counter.sv
module beep_half_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_q
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (phase_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R4
  cnt_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |=> $stable(cnt_q));
endmodule

// File: rtl/beep_regs.sv
module beep_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_LO = 10,
  parameter int unsigned SEL_HI = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic                     reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  output logic [DATA_W-1:0]        reg_rdata,
  output logic                     en_q,
  output logic [SEL_HI-SEL_LO:0]   sel_q
);
  localparam int unsigned SEL_W = SEL_HI - SEL_LO + 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr) sel_q <= reg_wdata[SEL_HI:SEL_LO];
      else          en_q  <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr) reg_rdata[SEL_HI:SEL_LO] = sel_q;
    else          reg_rdata[0] = en_q;
  end

  // R3
  sel_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> (reg_rdata[SEL_LO-1:0] == '0 && reg_rdata[DATA_W-1:SEL_HI+1] == '0));

  // R2
  en_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (reg_rdata[DATA_W-1:1] == '0));

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> (en_q == $past(reg_wdata[0])));

  localparam int unsigned SEL_W_USED = SEL_W;
endmodule

// File: rtl/beep_tap_sel.sv
module beep_tap_sel
  import beep_pkg::*;
#(
  parameter int unsigned CNT_W  = 19,
  parameter int unsigned SEL_LO = 10,
  parameter int unsigned SEL_HI = 18
) (
  input  logic [SEL_HI-SEL_LO:0]      sel_bits,
  input  logic [1:0]                  ratio,
  input  logic [CNT_W-1:0]            cnt,
  output logic                        tap_ok,
  output logic [$clog2(CNT_W)-1:0]    base_idx,
  output logic [$clog2(CNT_W)-1:0]    eff_idx,
  output logic                        tap_bit
);
  localparam int unsigned SEL_W = SEL_HI - SEL_LO + 1;
  localparam int unsigned IDX_W = $clog2(CNT_W);

  logic [IDX_W-1:0] shift_amt;

  always_comb begin
    base_idx = '0;
    for (int i = 0; i < SEL_W; i++) begin
      if (sel_bits[i]) base_idx = IDX_W'(SEL_LO + i);
    end
    tap_ok = ($countones(sel_bits) == 1);
  end

  always_comb begin
    case (clk_ratio_e'(ratio))
      RATIO_HALF: shift_amt = IDX_W'(HALF_SHIFT);
      RATIO_SLOW: shift_amt = IDX_W'(SLOW_SHIFT);
      default:    shift_amt = '0;
    endcase
    // clamp the corrected index at counter bit 0
    eff_idx = (base_idx >= shift_amt) ? (base_idx - shift_amt) : '0;
    tap_bit = cnt[eff_idx];
  end
endmodule

// File: rtl/tone_beep_gen.sv
module tone_beep_gen
  import beep_pkg::*;
#(
  parameter int unsigned CNT_W  = 19,
  parameter int unsigned SEL_LO = 10,
  parameter int unsigned SEL_HI = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        clk_ratio,
  output logic              beep_out
);
  localparam int unsigned SEL_W = SEL_HI - SEL_LO + 1;
  localparam int unsigned IDX_W = $clog2(CNT_W);

  logic [CNT_W-1:0] cnt;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             tap_ok;
  logic             tap_bit;
  logic [IDX_W-1:0] base_idx;
  logic [IDX_W-1:0] eff_idx;
  logic             beep_q;

  beep_half_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_q (cnt)
  );

  beep_regs #(.DATA_W(DATA_W), .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_q      (en_q),
    .sel_q     (sel_q)
  );

  beep_tap_sel #(.CNT_W(CNT_W), .SEL_LO(SEL_LO), .SEL_HI(SEL_HI)) u_tap (
    .sel_bits (sel_q),
    .ratio    (clk_ratio),
    .cnt      (cnt),
    .tap_ok   (tap_ok),
    .base_idx (base_idx),
    .eff_idx  (eff_idx),
    .tap_bit  (tap_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) beep_q <= 1'b0;
    else        beep_q <= en_q & tap_ok & tap_bit;
  end

  assign beep_out = beep_q;

  // R8
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> !beep_out);

  // R7
  off_when_bad_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tap_ok) |-> !beep_out);

  // R6
  half_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_ok && clk_ratio == RATIO_HALF) |-> (eff_idx == base_idx - IDX_W'(HALF_SHIFT)));

  // R6
  slow_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_ok && clk_ratio == RATIO_SLOW) |-> (eff_idx == base_idx - IDX_W'(SLOW_SHIFT)));

  // R5
  full_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_ok && (clk_ratio == RATIO_FULL || clk_ratio == RATIO_RSVD)) |-> (eff_idx == base_idx));
endmodule

// File: tb/tb_tone_beep_gen.sv
module tb_tone_beep_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  clk_ratio = 2'd0;
  logic        beep_out;

  always #2.5 clk = ~clk;

  tone_beep_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_ratio(clk_ratio), .beep_out(beep_out)
  );

  int vectors = 0;
  int fails = 0;
  string req = "R1";
  int cycles = 0;

  // behavioural reference state
  int m_ph, m_cnt, m_en, m_sel, m_out;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_en = 0; m_sel = 0; m_out = 0;
    end else begin
      int ones, idx, sh, eff, nxt;
      ones = 0; idx = 0;
      for (int i = 0; i < 9; i++)
        if ((m_sel >> i) & 1) begin ones++; idx = 10 + i; end
      sh = (clk_ratio == 2'd1) ? 1 : (clk_ratio == 2'd2) ? 5 : 0;
      eff = (idx >= sh) ? idx - sh : 0;
      nxt = (m_en != 0 && ones == 1) ? ((m_cnt >> eff) & 1) : 0;
      if (reg_wr) begin
        if (reg_addr) m_sel = (reg_wdata >> 10) & 9'h1ff;
        else          m_en  = reg_wdata & 1;
      end
      if (m_ph != 0) m_cnt = (m_cnt + 1) & 32'h7ffff;
      m_ph ^= 1;
      m_out = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] exp_rd;
      exp_rd = reg_addr ? 32'(m_sel << 10) : 32'(m_en);
      vectors++;
      if (beep_out !== m_out[0]) begin
        fails++;
        $display("FAIL %s: beep_out=%0b expected %0b at cycle %0d", req, beep_out, m_out[0], cycles);
      end
      vectors++;
      if (reg_rdata !== exp_rd) begin
        fails++;
        $display("FAIL %s: reg_rdata=%h expected %h", req, reg_rdata, exp_rd);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic period(string r, int exp);
    int n;
    logic prev;
    n = 0;
    prev = beep_out;
    // wait for first rising edge
    while (!(beep_out && !prev) && n < 20000) begin
      prev = beep_out; @(negedge clk); n++;
    end
    n = 0;
    prev = beep_out;
    @(negedge clk); n++;
    while (!(beep_out && !prev) && n < 20000) begin
      prev = beep_out; @(negedge clk); n++;
    end
    check(r, n, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    req = "R1";
    @(negedge clk);
    check("R1", beep_out, 0);
    reg_addr = 1'b0; #1; check("R1", reg_rdata, 0);
    reg_addr = 1'b1; #1; check("R1", reg_rdata, 0);
    step(1);

    // R2 enable register with reserved bits
    req = "R2";
    wr(1'b0, 32'hffff_fffe);
    reg_addr = 1'b0; #1; check("R2", reg_rdata, 32'h0);
    wr(1'b0, 32'hffff_ffff);
    reg_addr = 1'b0; #1; check("R2", reg_rdata, 32'h1);

    // R3 select register with reserved bits
    req = "R3";
    wr(1'b1, 32'hffff_ffff);
    reg_addr = 1'b1; #1; check("R3", reg_rdata, 32'h0007_fc00);
    step(300);

    // R7 multiple bits: output held low
    req = "R7";
    step(5000);
    wr(1'b1, 32'h0000_0000);
    step(5000);

    // R5 full speed, bit 10
    req = "R5";
    wr(1'b1, 32'h0000_0400);
    step(100);
    period("R5", 4096);
    req = "R5";
    wr(1'b1, 32'h0000_0800);
    step(3000);

    // R6 half speed with bit 11, slow with bit 15, reserved code as full
    req = "R6";
    clk_ratio = 2'd1;
    period("R6", 4096);
    wr(1'b1, 32'h0000_8000);
    clk_ratio = 2'd2;
    period("R6", 4096);
    wr(1'b1, 32'h0000_0400);
    clk_ratio = 2'd3;
    period("R6", 4096);
    clk_ratio = 2'd0;

    // R8 disable, counter keeps running, re-enable
    req = "R8";
    wr(1'b0, 32'h0);
    step(3000);
    wr(1'b0, 32'h1);
    step(3000);

    // R9 back-to-back writes, output follows within one edge
    req = "R9";
    wr(1'b1, 32'h0000_0c00);
    step(50);
    wr(1'b1, 32'h0000_1000);
    reg_addr = 1'b1; #1; check("R9", reg_rdata, 32'h0000_1000);
    step(9000);

    // R4 counter continuity checked through reference compares above
    req = "R4";
    step(2000);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule